// File: doc/BRIEF.md
# Compressed Instruction Expander (Width-Dependent Subset)

This combinational unit turns a 16-bit compressed instruction into the 32-bit base instruction that does the same work. If the half-word is not part of the subset it handles, or is not allowed at the configured register width, it raises an illegal flag instead. A parameter sets the register width to 32 or 64 bits. The subset is the set of encodings whose meaning depends on that width:

- doubleword load and store, in both the register-based and the stack-pointer-based forms;
- the shared encoding that means jump-and-link on a 32-bit machine and add-immediate-word on a 64-bit machine;
- the register-register word add and word subtract.

A fetch stage places the half-word on the input together with a valid strobe. In the same cycle it takes the expanded word, the illegal flag and a matching valid strobe from the outputs. The unit holds no state, so results appear in the same cycle.

Top module: `cexp_expander`

## Requirements
- R1: With XLEN=64, quadrant 00 and funct3 011 expand to a doubleword load with opcode 0000011 and funct3 011. The destination is x(8+h[4:2]) and the base is x(8+h[9:7]). The zero-extended offset is h[6:5]*64 + h[12:10]*8.
- R2: With XLEN=64, quadrant 00 and funct3 111 expand to a doubleword store with opcode 0100011 and funct3 011. The source is x(8+h[4:2]), the base is x(8+h[9:7]), and the offset is the same as in R1.
- R3: With XLEN=32, quadrant 01 and funct3 001 expand to jump-and-link with opcode 1101111, writing the return address to x1. The signed immediate is built from these bits, with an implicit zero LSB: imm[11]=h12, imm[10]=h8, imm[9:8]=h[10:9], imm[7]=h6, imm[6]=h7, imm[5]=h2, imm[4]=h11, imm[3:1]=h[5:3].
- R4: With XLEN=64, the same encoding expands to add-immediate-word with opcode 0011011 and funct3 000, where rd=rs1=h[11:7]. The immediate is the sign-extended {h12,h[6:2]}. When h[11:7]=0 the half-word is illegal.
- R5: With XLEN=64, quadrant 01 with h[15:10]=100111 expands to word subtract when h[6:5]=00 and to word add when h[6:5]=01. Both use opcode 0111011 and funct3 000; funct7 is 0100000 for subtract and 0000000 for add. rd=rs1=x(8+h[9:7]) and rs2=x(8+h[4:2]).
- R6: With XLEN=64, quadrant 10 and funct3 011 expand to a doubleword load from base x2, with rd=h[11:7]. The offset is h[4:2]*64 + h12*32 + h[6:5]*8. When rd=0 the half-word is illegal.
- R7: With XLEN=64, quadrant 10 and funct3 111 expand to a doubleword store to base x2, with rs2=h[6:2]. The offset is h[9:7]*64 + h[12:10]*8.
- R8: Every other valid half-word raises illegal and drives an instruction of all zeros. This includes each form above when it appears at the width where it is not allowed.
- R9: The output valid strobe equals the input valid strobe. While the input valid strobe is low, the instruction is zero and illegal is low.
- R10: Every legal expansion has instruction bits [1:0] equal to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| halfWord | input | 16 | Compressed instruction |
| inValid | input | 1 | Half-word is present |
| instr | output | 32 | Expanded instruction, zero if illegal or idle |
| illegal | output | 1 | Half-word is not expandable at this width |
| outValid | output | 1 | Copy of inValid |

## Verification
The bench sweeps all 65,536 half-words against both a 64-bit and a 32-bit instance. It compares each one with an arithmetic model of the requirements, so every offset scramble and every reserved-register case is covered.

Typical faults the sweep exposes:
- A swapped bit pair in the jump immediate, such as imm[6] and imm[7], shows up as a wrong target on half of the jump encodings.
- A missing width guard lets a doubleword load expand on the 32-bit instance.
- A missing x0 guard produces an add-immediate-word or stack load into x0 instead of illegal.
- Accepting h[6:5]=1x in the word arithmetic group emits a bogus instruction where illegal is expected.

// File: rtl/cexp_pkg.sv
`timescale 1ns/1ps
package cexp_pkg;
  localparam int HALF_W = 16;
  localparam int INSTR_W = 32;

  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_JAL   = 7'b1101111;
  localparam logic [6:0] OP_IMMW  = 7'b0011011;
  localparam logic [6:0] OP_REGW  = 7'b0111011;
  localparam logic [2:0] F3_DBL   = 3'b011;
  localparam logic [4:0] REG_RA   = 5'd1;
  localparam logic [4:0] REG_SP   = 5'd2;

  // one strobe per expansion form, ordered MSB first
  typedef struct packed {
    logic ld;
    logic sd;
    logic ldsp;
    logic sdsp;
    logic jal;
    logic addiw;
    logic subw;
    logic addw;
  } cexp_sel_t;

  localparam int NUM_FORMS = $bits(cexp_sel_t);

  function automatic logic [4:0] primeReg(input logic [2:0] r);
    return {2'b01, r};
  endfunction

  function automatic logic [31:0] packI(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] packS(input logic [11:0] imm, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [31:0] packR(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {f7, rs2, rs1, 3'b000, rd, op};
  endfunction

  function automatic logic [31:0] packJ(input logic [20:0] imm, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, op};
  endfunction
endpackage

// File: rtl/cexp_ctrl.sv
`timescale 1ns/1ps
module cexp_ctrl
  import cexp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic      inValid,
  input  logic [5:0] funcHi,   // half-word bits [15:10]
  input  logic [4:0] rdField,  // half-word bits [11:7]
  input  logic [1:0] midSel,   // half-word bits [6:5]
  input  logic [1:0] quad,     // half-word bits [1:0]
  output cexp_sel_t sel,
  output logic      illegal
);
  localparam bit IS64 = (XLEN == 64);

  logic [2:0] f3;
  logic rawLd, rawSd, rawLdsp, rawSdsp, rawShared, rawArithW;
  cexp_sel_t hit;

  assign f3 = funcHi[5:3];

  always_comb begin
    rawLd     = (quad == 2'b00) && (f3 == 3'b011);
    rawSd     = (quad == 2'b00) && (f3 == 3'b111);
    rawLdsp   = (quad == 2'b10) && (f3 == 3'b011);
    rawSdsp   = (quad == 2'b10) && (f3 == 3'b111);
    rawShared = (quad == 2'b01) && (f3 == 3'b001);
    rawArithW = (quad == 2'b01) && (funcHi == 6'b100111);
  end

  generate
    if (IS64) begin : g_wide
      always_comb begin
        hit       = '0;
        hit.ld    = rawLd;
        hit.sd    = rawSd;
        hit.ldsp  = rawLdsp && (rdField != 5'd0);
        hit.sdsp  = rawSdsp;
        hit.addiw = rawShared && (rdField != 5'd0);
        hit.subw  = rawArithW && (midSel == 2'b00);
        hit.addw  = rawArithW && (midSel == 2'b01);
      end
    end else begin : g_narrow
      always_comb begin
        hit     = '0;
        hit.jal = rawShared;
      end
    end
  endgenerate

  assign sel     = inValid ? hit : '0;
  assign illegal = inValid && (hit == '0);
endmodule

// File: rtl/cexp_datapath.sv
`timescale 1ns/1ps
module cexp_datapath
  import cexp_pkg::*;
(
  input  logic [12:2]  hw,   // half-word bits [12:2]
  input  cexp_sel_t    sel,
  output logic [INSTR_W-1:0] instr
);
  logic [4:0]  rdFull, rs2Full, rdPrime, rs1Prime;
  logic [11:0] ldOff, ldspOff, sdspOff, addiwImm;
  logic [20:0] jalImm;
  logic [INSTR_W-1:0] cand [NUM_FORMS];
  logic [NUM_FORMS-1:0] selVec;

  assign rdFull   = hw[11:7];
  assign rs2Full  = hw[6:2];
  assign rdPrime  = primeReg(hw[4:2]);
  assign rs1Prime = primeReg(hw[9:7]);

  assign ldOff    = {4'b0, hw[6:5], hw[12:10], 3'b000};
  assign ldspOff  = {3'b0, hw[4:2], hw[12], hw[6:5], 3'b000};
  assign sdspOff  = {3'b0, hw[9:7], hw[12:10], 3'b000};
  assign addiwImm = {{6{hw[12]}}, hw[12], hw[6:2]};
  assign jalImm   = {{9{hw[12]}}, hw[12], hw[8], hw[10:9], hw[6], hw[7], hw[2],
                     hw[11], hw[5:3], 1'b0};

  // candidates indexed to match the packed struct bit order
  assign cand[7] = packI(ldOff, rs1Prime, F3_DBL, rdPrime, OP_LOAD);
  assign cand[6] = packS(ldOff, rdPrime, rs1Prime, F3_DBL, OP_STORE);
  assign cand[5] = packI(ldspOff, REG_SP, F3_DBL, rdFull, OP_LOAD);
  assign cand[4] = packS(sdspOff, rs2Full, REG_SP, F3_DBL, OP_STORE);
  assign cand[3] = packJ(jalImm, REG_RA, OP_JAL);
  assign cand[2] = packI(addiwImm, rdFull, 3'b000, rdFull, OP_IMMW);
  assign cand[1] = packR(7'b0100000, rdPrime, rs1Prime, rs1Prime, OP_REGW);
  assign cand[0] = packR(7'b0000000, rdPrime, rs1Prime, rs1Prime, OP_REGW);

  assign selVec = sel;

  always_comb begin
    instr = '0;
    for (int i = 0; i < NUM_FORMS; i++) begin
      instr = instr | (cand[i] & {INSTR_W{selVec[i]}});
    end
  end
endmodule

// File: rtl/cexp_expander.sv
`timescale 1ns/1ps
module cexp_expander
  import cexp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [15:0] halfWord,
  input  logic        inValid,
  output logic [31:0] instr,
  output logic        illegal,
  output logic        outValid
);
  cexp_sel_t sel;

  cexp_ctrl #(.XLEN(XLEN)) u_ctrl (
    .inValid (inValid),
    .funcHi  (halfWord[15:10]),
    .rdField (halfWord[11:7]),
    .midSel  (halfWord[6:5]),
    .quad    (halfWord[1:0]),
    .sel     (sel),
    .illegal (illegal)
  );

  cexp_datapath u_dp (
    .hw    (halfWord[12:2]),
    .sel   (sel),
    .instr (instr)
  );

  assign outValid = inValid;
endmodule

// File: rtl/cexp_checker.sv
`timescale 1ns/1ps
module cexp_checker #(
  parameter int XLEN = 64
) (
  input logic [2:0]  f3,
  input logic [1:0]  quad,
  input logic [4:0]  rdField,
  input logic        inValid,
  input logic [31:0] instr,
  input logic        illegal,
  input logic        outValid
);
  always_comb begin
    a_r9_valid_follows: assert (outValid == inValid);
    if (!inValid) begin
      a_r9_idle_quiet: assert (instr == 32'd0 && !illegal);
    end
    if (illegal) begin
      a_r8_illegal_zero: assert (instr == 32'd0);
    end
    if (inValid && !illegal) begin
      a_r10_low_bits: assert (instr[1:0] == 2'b11);
    end
    if (XLEN == 64 && inValid && quad == 2'b01 && f3 == 3'b001 && rdField == 5'd0) begin
      a_r4_addiw_x0: assert (illegal);
    end
    if (XLEN == 64 && inValid && quad == 2'b10 && f3 == 3'b011 && rdField == 5'd0) begin
      a_r6_ldsp_x0: assert (illegal);
    end
    if (XLEN == 32) begin
      a_r3_no_wide_ops: assert (instr[6:0] != 7'b0111011 && instr[6:0] != 7'b0011011);
    end else begin
      a_r3_no_jal_wide: assert (instr[6:0] != 7'b1101111);
    end
  end
endmodule

bind cexp_expander cexp_checker #(.XLEN(XLEN)) u_chk (
  .f3      (halfWord[15:13]),
  .quad    (halfWord[1:0]),
  .rdField (halfWord[11:7]),
  .inValid (inValid),
  .instr   (instr),
  .illegal (illegal),
  .outValid(outValid)
);

// File: tb/tb_cexp_expander.sv
`timescale 1ns/1ps
module tb_cexp_expander;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] halfWord = '0;
  logic        inValid = 1'b0;
  logic [31:0] instr64, instr32;
  logic        ill64, ill32, ov64, ov32;
  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cycles = 0;

  cexp_expander #(.XLEN(64)) dut (
    .halfWord(halfWord), .inValid(inValid), .instr(instr64), .illegal(ill64), .outValid(ov64));
  cexp_expander #(.XLEN(32)) dut32 (
    .halfWord(halfWord), .inValid(inValid), .instr(instr32), .illegal(ill32), .outValid(ov32));

  function automatic logic [31:0] mkI(input int imm, input int rs1, input int f3,
                                      input int rd, input logic [6:0] op);
    logic [31:0] iv = imm;
    logic [31:0] a = rs1;
    logic [31:0] f = f3;
    logic [31:0] d = rd;
    return {iv[11:0], a[4:0], f[2:0], d[4:0], op};
  endfunction

  function automatic logic [31:0] mkS(input int imm, input int rs2, input int rs1);
    logic [31:0] iv = imm;
    logic [31:0] b = rs2;
    logic [31:0] a = rs1;
    return {iv[11:5], b[4:0], a[4:0], 3'b011, iv[4:0], 7'b0100011};
  endfunction

  // expected instruction (zero means illegal) and requirement tag
  function automatic logic [31:0] refModel(input logic [15:0] h, input bit w64,
                                           output string tag);
    int q = h[1:0];
    int f = h[15:13];
    int rdF = h[11:7];
    int rdP = 8 + h[4:2];
    int rsP = 8 + h[9:7];
    int imm;
    logic [31:0] iv;
    tag = "R8";
    if (q == 0 && f == 3 && w64) begin
      tag = "R1";
      return mkI(h[6:5] * 64 + h[12:10] * 8, rsP, 3, rdP, 7'b0000011);
    end
    if (q == 0 && f == 7 && w64) begin
      tag = "R2";
      return mkS(h[6:5] * 64 + h[12:10] * 8, rdP, rsP);
    end
    if (q == 1 && f == 1 && !w64) begin
      tag = "R3";
      imm = h[11] * 16 + h[10:9] * 256 + h[8] * 1024 + h[7] * 64 + h[6] * 128
          + h[5:3] * 2 + h[2] * 32 - h[12] * 2048;
      iv = imm;
      return {iv[20], iv[10:1], iv[11], iv[19:12], 5'd1, 7'b1101111};
    end
    if (q == 1 && f == 1 && w64) begin
      tag = "R4";
      if (rdF == 0) return 32'd0;
      imm = h[6:2] - (h[12] ? 32 : 0);
      return mkI(imm, rdF, 0, rdF, 7'b0011011);
    end
    if (q == 1 && h[15:10] == 6'b100111 && w64 && h[6] == 1'b0) begin
      tag = "R5";
      return {h[5] ? 7'b0000000 : 7'b0100000, 5'(rdP), 5'(rsP), 3'b000, 5'(rsP), 7'b0111011};
    end
    if (q == 2 && f == 3 && w64) begin
      tag = "R6";
      if (rdF == 0) return 32'd0;
      return mkI(h[4:2] * 64 + h[12] * 32 + h[6:5] * 8, 2, 3, rdF, 7'b0000011);
    end
    if (q == 2 && f == 7 && w64) begin
      tag = "R7";
      return mkS(h[9:7] * 64 + h[12:10] * 8, h[6:2], 2);
    end
    return 32'd0;
  endfunction

  task automatic check(input string tag, input string what, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s h=%h actual=%h expected=%h", tag, what, halfWord, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    string tag;
    logic [31:0] e;
    // idle state, R9
    halfWord = 16'h7CE8;
    inValid  = 1'b0;
    #3;
    check("R9", "idle w64", {ill64, instr64}, 33'd0);
    check("R9", "idle w32", {ill32, instr32}, 33'd0);
    check("R9", "outValid low", {31'd0, ov64, ov32}, 33'd0);
    @(negedge clk);
    inValid = 1'b1;
    // directed values
    halfWord = 16'h7CE8; #1;
    check("R1", "ld x10,248(x9)", {ill64, instr64}, {1'b0, 32'h0F84B503});
    check("R8", "ld at w32", {ill32, instr32}, {1'b1, 32'd0});
    check("R9", "outValid high", {31'd0, ov64, ov32}, 33'd3);
    halfWord = 16'h2001; #1;
    check("R3", "jal x1,0", {ill32, instr32}, {1'b0, 32'h000000EF});
    check("R4", "addiw x0 illegal", {ill64, instr64}, {1'b1, 32'd0});
    halfWord = 16'h2405; #1;
    check("R4", "addiw x8,x8,1", {ill64, instr64}, {1'b0, 32'h0014041B});
    // exhaustive sweep of both widths
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      halfWord = 16'(i);
      #1;
      e = refModel(halfWord, 1'b1, tag);
      check(tag, "sweep w64", {ill64, instr64}, {e == 32'd0, e});
      if (e != 32'd0) check("R10", "low bits w64", {31'd0, instr64[1:0]}, 33'd3);
      e = refModel(halfWord, 1'b0, tag);
      check(tag, "sweep w32", {ill32, instr32}, {e == 32'd0, e});
    end
    finishRun();
  end
endmodule